// File: doc/BRIEF.md
# Drum Word Parity Formatter and Serializer

This block sits between a host that moves 30-bit words in parallel and a drum channel that moves 32-bit words one bit at a time. For a write, the host word is cut into a low and a high 15-bit half. Each half gets an odd-parity bit, which makes two 16-bit bytes. The resulting 32 bits then go out serially, one bit for each pulse of a bit-enable strobe.

For a read, the block gathers 32 serial bits under the same strobe. It removes the two parity bits and checks each byte on its own. It then presents the 30-bit host word together with one error flag per byte.

A single shifter serves both directions. It accepts a new operation only while it is idle, and it reports `busy` for the whole length of a transfer.

Top module: `drum_word_codec`

## Requirements
- R1: While reset is held and right after it, `busy`, `ser_out`, `rd_valid`, `rd_word` and `rd_err` are all 0.
- R2: A write forms the drum word as follows. Drum bits 14..0 are host bits 14..0 and drum bit 15 is the parity of the low half. Drum bits 30..16 are host bits 29..15 and drum bit 31 is the parity of the high half. Each parity bit makes its 16-bit byte hold an odd number of ones.
- R3: Drum bit 0 goes out first. `ser_out` presents drum bit k from the acceptance of the load until the clock edge of the (k+1)-th `bit_en` pulse. It holds steady between pulses.
- R4: `busy` rises in the cycle after an accepted start. It stays high through gaps between pulses and falls after the edge of the 32nd `bit_en` pulse.
- R5: `wr_load` and `rd_start` have no effect while `busy` is high.
- R6: When `wr_load` and `rd_start` arrive together while idle, the write is performed.
- R7: A read captures `ser_in` on each of 32 `bit_en` pulses, with the first bit taken as drum bit 0. In the cycle after the 32nd pulse, `rd_valid` is high for exactly one cycle. At that point `rd_word` holds drum bits 30..16 and 14..0, packed to host bits 29..0.
- R8: `rd_err[0]` is 1 when drum bits 15..0 of the received word hold an even number of ones. `rd_err[1]` is 1 when drum bits 31..16 hold an even number of ones. Both flags are valid with `rd_valid`.
- R9: `rd_word` and `rd_err` keep their values until the next read completes. Writes do not alter them.
- R10: `ser_out` is 0 while idle and during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit moves per cycle this is high |
| wr_load | input | 1 | Start a write using `host_w` |
| host_w | input | 30 | Host word to write |
| rd_start | input | 1 | Start a read |
| ser_in | input | 1 | Serial data from the drum |
| ser_out | output | 1 | Serial data to the drum |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle strobe: read word ready |
| rd_word | output | 30 | Received host word |
| rd_err | output | 2 | Per-byte parity error, bit 0 = low byte |

## Verification
The hardest condition to reach from the ports is a start request that lands in the middle of a transfer. It has to come between `bit_en` pulses, after some bits have already moved, and it carries a different word. The bench spaces every pulse with an idle cycle so that such cycles exist. During one write it raises `wr_load` and `rd_start` in such a gap, then checks that the full serial stream still matches the original word. Parity failures in each byte alone and in both bytes together are produced by flipping one bit per byte of known-good drum words before they are fed in.

// File: rtl/drum_word_codec.sv
module drum_word_codec #(
  parameter int HALF_W = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  wr_load,
  input  logic [2*HALF_W-1:0]   host_w,
  input  logic                  rd_start,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic                  busy,
  output logic                  rd_valid,
  output logic [2*HALF_W-1:0]   rd_word,
  output logic [1:0]            rd_err
);
  localparam int HOST_W = 2 * HALF_W;
  localparam int BYTE_W = HALF_W + 1;
  localparam int DRUM_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(DRUM_W + 1);

  logic [DRUM_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              wr_mode;

  wire start = !busy && (wr_load || rd_start);
  wire last  = busy && bit_en && (cnt == CNT_W'(DRUM_W - 1));

  wire [HALF_W-1:0] lo_h = host_w[HALF_W-1:0];
  wire [HALF_W-1:0] hi_h = host_w[HOST_W-1:HALF_W];
  wire [DRUM_W-1:0] tx_word = {~^hi_h, hi_h, ~^lo_h, lo_h};
  wire [DRUM_W-1:0] rx_next = {ser_in, shreg[DRUM_W-1:1]};

  assign ser_out = busy & wr_mode & shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      wr_mode  <= 1'b0;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
      rd_err   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        wr_mode <= wr_load;
        cnt     <= '0;
        shreg   <= wr_load ? tx_word : '0;
      end else if (busy && bit_en) begin
        cnt   <= cnt + 1'b1;
        shreg <= wr_mode ? {1'b0, shreg[DRUM_W-1:1]} : rx_next;
        if (last) begin
          busy <= 1'b0;
          if (!wr_mode) begin
            rd_valid <= 1'b1;
            rd_word  <= {rx_next[DRUM_W-2 -: HALF_W], rx_next[HALF_W-1:0]};
            rd_err   <= {~^rx_next[DRUM_W-1:BYTE_W], ~^rx_next[BYTE_W-1:0]};
          end
        end
      end
    end
  end

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (wr_load || rd_start)) |=> busy);
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> busy);
  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en && (wr_load || rd_start)) |=> $stable(shreg) && $stable(cnt));
  assert_serial_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(ser_out));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_valid_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy && $past(busy));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_word) && $stable(rd_err));
  assert_quiet_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !wr_mode) |-> !ser_out);
endmodule

// File: tb/drum_word_codec_tb.sv
module drum_word_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {host word, expected drum word}
  localparam logic [61:0] VEC [NV] = '{
    {30'h00000000, 32'h80008000},
    {30'h3FFFFFFF, 32'h7FFF7FFF},
    {30'h00000001, 32'h80000001},
    {30'h00008000, 32'h00018000},
    {30'h00000003, 32'h80008003},
    {30'h15555555, 32'h2AAAD555}
  };

  logic clk = 0, rst_n = 0, bit_en = 0, wr_load = 0, rd_start = 0, ser_in = 0;
  logic [29:0] host_w = '0;
  logic ser_out, busy, rd_valid;
  logic [29:0] rd_word;
  logic [1:0] rd_err;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drum_word_codec dut_i (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_load(wr_load),
    .host_w(host_w), .rd_start(rd_start), .ser_in(ser_in), .ser_out(ser_out),
    .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word), .rd_err(rd_err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [29:0] w, input logic [31:0] exp,
                          input logic also_rd, input logic intrude);
    logic [31:0] got = '0;
    logic quiet = 1'b1;
    @(negedge clk); wr_load = 1; rd_start = also_rd; host_w = w;
    @(negedge clk); wr_load = 0; rd_start = 0; host_w = ~w;
    chk("R4 busy after load", busy, 1);
    for (int k = 0; k < 32; k++) begin
      got[k] = ser_out;
      bit_en = 1;
      @(negedge clk); bit_en = 0;
      if (k < 31 && !busy) quiet = 0;
      if (intrude && k == 7) begin wr_load = 1; rd_start = 1; end
      @(negedge clk); wr_load = 0; rd_start = 0;
    end
    chk("R2/R3 serial drum word", got, exp);
    if (intrude) chk("R5 busy held through transfer", quiet, 1);
    chk("R4 idle after 32 pulses", busy, 0);
    chk("R10 line quiet when idle", ser_out, 0);
  endtask

  task automatic do_read(input logic [31:0] d, input logic [29:0] exp_w, input logic [1:0] exp_e);
    logic line_ok = 1'b1;
    @(negedge clk); rd_start = 1;
    @(negedge clk); rd_start = 0;
    for (int k = 0; k < 32; k++) begin
      ser_in = d[k]; bit_en = 1;
      if (ser_out !== 1'b0) line_ok = 0;
      @(negedge clk); bit_en = 0;
      if (k < 31) begin
        if (rd_valid) line_ok = 0;
        @(negedge clk);
      end
    end
    chk("R10 line quiet during read", line_ok, 1);
    chk("R7 valid after 32nd pulse", rd_valid, 1);
    chk("R7 host word", rd_word, exp_w);
    chk("R8 byte flags", rd_err, exp_e);
    @(negedge clk);
    chk("R7 single-cycle valid", rd_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] held_w;
    logic [1:0] held_e;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, ser_out, rd_valid, rd_word, rd_err}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {busy, ser_out, rd_valid, rd_word, rd_err}, '0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][61:32], VEC[i][31:0], 0, 0);
      do_read(VEC[i][31:0], VEC[i][61:32], 2'b00);
    end

    // R8 corrupted bytes
    do_read(32'h80008000 ^ 32'h00000001, 30'h00000001, 2'b01);
    do_read(32'h80008000 ^ 32'h80000000, 30'h00000000, 2'b10);
    do_read(32'h2AAAD555 ^ 32'h00010004, 30'h15555551 ^ 30'h00008000, 2'b11);

    // R5 start requests mid-transfer ignored
    do_write(30'h00000003, 32'h80008003, 0, 1);
    // R6 write wins over simultaneous read request
    do_write(30'h00008000, 32'h00018000, 1, 0);

    // R9 hold across idle time and a write
    do_read(32'h80008000 ^ 32'h00000001, 30'h00000001, 2'b01);
    held_w = rd_word; held_e = rd_err;
    do_write(30'h3FFFFFFF, 32'h7FFF7FFF, 0, 0);
    repeat (5) @(negedge clk);
    chk("R9 word held", rd_word, held_w);
    chk("R9 flags held", rd_err, held_e);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule